// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single channel of a general-purpose timer. It sits next to a free-running counter whose value arrives on `cnt_val`. A small byte-wide register bus gives software access to an 8-bit control/status register and to the channel value register.

The channel works in one of two modes:
- **Capture.** The channel waits for a selected edge on `pin_in`. When the edge arrives it copies the counter into the value register and raises the event flag.
- **Compare.** The channel raises the flag when the counter reaches the value register. On the same edge it can set, clear or toggle `pin_out`.

The flag drives `irq` when interrupts are enabled. Software clears the flag with a two-step handshake: first a read that sees the flag set, then a write of 0 to the flag bit. Any new event that arrives between the two steps cancels the pending clear. This way an event is never silently dropped.

Top module: `tmr_chan_reg`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), the following all read 0: the control register, the flag, the value register, `irq` and `pin_out`.
- R2: Control register (address 0) layout:
  - bit 7: flag (read-only through writes)
  - bit 6: interrupt enable
  - bit 5: mode B
  - bit 4: mode A
  - bits 3:2: edge/action select
  - bit 1: overflow-toggle bit (stored and read back)
  - bit 0: max-duty bit (stored and read back)
  - Bits 6 to 0 read back exactly what was last written.
- R3: Capture mode is mode bits 5:4 = 00. The edge select picks the active edge:
  - 01: rising edge
  - 10: falling edge
  - 11: either edge
  - 00: none
  An active edge on `pin_in` sets the flag on the third rising clock edge after the pin changes. On that same edge the value register loads `cnt_val`. An edge that is not selected has no effect on the flag or the value register.
- R4: Compare mode is any nonzero setting of bits 5:4. In compare mode, a clock edge at which `cnt_val` equals the value register sets the flag.
- R5: On a compare match, the edge select acts on `pin_out`:
  - 01: toggle
  - 10: drive to 0
  - 11: drive to 1
  - 00: leave unchanged
- R6: Clearing the flag takes two accesses. First, a read of address 0 must return bit 7 = 1. Then a later write to address 0 with bit 7 = 0 clears the flag.
- R7: A write of 0 to bit 7 that was not preceded by a read seeing the flag set leaves the flag at 1.
- R8: A capture or compare event that occurs after the arming read and before the write of 0 makes that write ineffective, so the flag stays 1.
- R9: Writing 1 to bit 7 never changes the flag.
- R10: `irq` is 1 exactly when both the flag and the interrupt enable (bit 6) are 1.
- R11: With parameter `EVEN_CHAN` = 0, bit 5 is reserved: it always reads 0, whatever is written to it.
- R12: The value register is accessed byte by byte. Address 1 holds bits 7:0 and address 2 holds bits 15:8. Software can write it, and writes read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | CNT_W | Free-running counter value |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 control, 1.. value bytes) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pin_in | input | 1 | Asynchronous capture input |
| pin_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |

## Verification
The main corner case is an event that lands between the arming read and the write of 0. A design that ignores arming, or lets the write win over the event, clears the flag and loses the interrupt.

The bench also covers these cases:
- **Unarmed write of 0.** A design that clears on any 0 write fails here.
- **Write of 1 to the flag.** A design that writes the flag bit directly would set it.
- **Edges against the edge select.** Random edges are applied under every edge select. A wrong polarity decode flags the wrong edges, or latches the counter when it should not.
- **Compare pin actions.** Toggle, clear and set are each checked. A swapped select shows up as the wrong pin level.
- **Odd channel.** Bit 5 is checked to read 0 on an odd channel.

// File: rtl/tmr_chan_pkg.sv
// Package: shared types and field positions for the timer channel.
// Assumes an 8-bit control register; field order is fixed because software
// decodes it.
package tmr_chan_pkg;

    localparam int FLAG_POS = 7;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_t;

    // Writable control fields, packed in bit order 6..0 of the register
    typedef struct packed {
        logic      ie;
        logic      mode_b;
        logic      mode_a;
        edge_sel_t esel;
        logic      ovf_tgl;
        logic      max_duty;
    } chan_ctrl_t;

    function automatic logic is_compare(input chan_ctrl_t c);
        return c.mode_b | c.mode_a;
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
// Module: synchronizes the capture pin and detects the selected edge.
// Assumes SYNC_STAGES >= 2; edge_hit is high for one cycle per pin change.
module tmr_edge_sync
    import tmr_chan_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin,
    input  edge_sel_t sel,
    output logic      edge_hit
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   pin_s;
    logic                   pin_prev;

    assign pin_s = chain[SYNC_STAGES-1];

    // Shift the raw pin through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2:0], pin};
    end

    // Remember last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) pin_prev <= 1'b0;
        else        pin_prev <= pin_s;
    end

    // Decode which edge counts as active
    always_comb begin
        unique case (sel)
            EDGE_RISE: edge_hit = pin_s & ~pin_prev;
            EDGE_FALL: edge_hit = ~pin_s & pin_prev;
            EDGE_BOTH: edge_hit = pin_s ^ pin_prev;
            default:   edge_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_flag_ctl.sv
// Module: event flag with read-then-write-0 clear handshake.
// Assumes rd_ctrl/wr_ctrl are single-cycle strobes for the control address;
// a new event always wins over a pending clear.
module tmr_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic event_hit,
    input  logic rd_ctrl,
    input  logic wr_ctrl,
    input  logic wr_flag_val,
    output logic flag
);
    logic armed;

    // Update flag and arm state; event first, then clear, then arming read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (event_hit) begin
            flag  <= 1'b1;
            armed <= 1'b0;
        end else if (wr_ctrl && !wr_flag_val && armed) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (rd_ctrl && flag) begin
            armed <= 1'b1;
        end
    end

    // R3 R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        event_hit |=> flag);
    // R9
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && wr_ctrl && wr_flag_val) |=> flag);
    // R7
    unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !armed) |=> flag);
    // R6 R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_ctrl && !wr_flag_val && !event_hit) |=> !flag);
endmodule

// File: rtl/tmr_out_ctl.sv
// Module: compare output pin action (toggle, clear, set) on a match.
// Assumes cmp_hit is already qualified by compare mode.
module tmr_out_ctl
    import tmr_chan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmp_hit,
    input  edge_sel_t act,
    output logic      pin_out
);
    // Apply the selected action to the pin on each match
    always_ff @(posedge clk) begin
        if (!rst_n) pin_out <= 1'b0;
        else if (cmp_hit) begin
            unique case (act)
                EDGE_RISE: pin_out <= ~pin_out;
                EDGE_FALL: pin_out <= 1'b0;
                EDGE_BOTH: pin_out <= 1'b1;
                default:   pin_out <= pin_out;
            endcase
        end
    end

    // R5
    pin_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_hit && act == EDGE_BOTH) |=> pin_out);
    // R5
    pin_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_hit && act == EDGE_FALL) |=> !pin_out);
    // R5
    pin_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_hit && act == EDGE_RISE) |=> (pin_out != $past(pin_out)));
endmodule

// File: rtl/tmr_chan_reg.sv
// Module: top of one timer capture/compare channel with its register bus.
// Assumes CNT_W is a multiple of 8; address 0 is control, addresses 1..N
// are value bytes from least significant upward; reads are combinational.
module tmr_chan_reg
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter bit EVEN_CHAN   = 1'b1,
    parameter int SYNC_STAGES = 2,
    localparam int NBYTES     = CNT_W / 8,
    localparam int ADDR_W     = $clog2(NBYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              irq
);
    chan_ctrl_t       ctrl;
    chan_ctrl_t       ctrl_wr;
    logic [CNT_W-1:0] value;
    logic             flag;
    logic             edge_hit;
    logic             cap_hit;
    logic             cmp_hit;
    logic             rd_ctrl;
    logic             wr_ctrl;
    logic             cmp_mode;

    assign rd_ctrl  = bus_rd && (bus_addr == '0);
    assign wr_ctrl  = bus_wr && (bus_addr == '0);
    assign cmp_mode = is_compare(ctrl);
    assign cap_hit  = edge_hit && !cmp_mode;
    assign cmp_hit  = cmp_mode && (cnt_val == value);

    // Mask the reserved mode bit on odd channels
    always_comb begin
        ctrl_wr = chan_ctrl_t'(bus_wdata[6:0]);
        if (!EVEN_CHAN) ctrl_wr.mode_b = 1'b0;
    end

    // Hold the control fields written by software
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= ctrl_wr;
    end

    // Value register: capture load wins over software byte writes
    always_ff @(posedge clk) begin
        if (!rst_n)       value <= '0;
        else if (cap_hit) value <= cnt_val;
        else if (bus_wr) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (bus_addr == ADDR_W'(b + 1)) value[8*b +: 8] <= bus_wdata;
            end
        end
    end

    // Read mux over control and value bytes
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) bus_rdata = {flag, ctrl};
        for (int b = 0; b < NBYTES; b++) begin
            if (bus_addr == ADDR_W'(b + 1)) bus_rdata = value[8*b +: 8];
        end
    end

    assign irq = flag & ctrl.ie;

    tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (pin_in),
        .sel      (ctrl.esel),
        .edge_hit (edge_hit)
    );

    tmr_flag_ctl u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .event_hit   (cap_hit | cmp_hit),
        .rd_ctrl     (rd_ctrl),
        .wr_ctrl     (wr_ctrl),
        .wr_flag_val (bus_wdata[FLAG_POS]),
        .flag        (flag)
    );

    tmr_out_ctl u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_hit (cmp_hit),
        .act     (ctrl.esel),
        .pin_out (pin_out)
    );

    // R3
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> (value == $past(cnt_val)));
    // R11
    rsvd_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !EVEN_CHAN |-> !ctrl.mode_b);
endmodule

// File: tb/tmr_chan_reg_test.sv
`timescale 1ns/1ps
module tmr_chan_reg_test;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] cnt_val = '0;
    logic             bus_rd = 1'b0;
    logic             bus_wr = 1'b0;
    logic [1:0]       bus_addr = '0;
    logic [7:0]       bus_wdata = '0;
    logic [7:0]       rdata, rdata_odd;
    logic             pin_in = 1'b0;
    logic             pin_out, pin_out_odd, irq, irq_odd;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tmr_chan_reg #(.CNT_W(CNT_W), .EVEN_CHAN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .irq(irq));

    tmr_chan_reg #(.CNT_W(CNT_W), .EVEN_CHAN(1'b0)) uut_odd (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_odd), .pin_in(pin_in), .pin_out(pin_out_odd),
        .irq(irq_odd));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic [7:0] d_odd);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = rdata; d_odd = rdata_odd;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_pin(input logic lvl);
        @(negedge clk);
        pin_in = lvl;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    // Expected capture decision from edge select and pin transition (R3)
    function automatic logic exp_cap(input logic [1:0] es, input logic from_l, input logic to_l);
        case (es)
            2'b01:   return !from_l && to_l;
            2'b10:   return from_l && !to_l;
            2'b11:   return from_l != to_l;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] rd16(input logic [7:0] lo, input logic [7:0] hi);
        return {hi, lo};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        logic [7:0] d, dodd, lo, hi;
        logic [15:0] cval;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        bus_read(2'd0, d, dodd); chk("R1 ctrl", d, 8'h00);
        bus_read(2'd1, lo, dodd); bus_read(2'd2, hi, dodd);
        chk("R1 value", rd16(lo, hi), 16'h0000);
        chk("R1 irq", irq, 1'b0); chk("R1 pin_out", pin_out, 1'b0);

        // R2 R9 control read/write; writing 1 to flag has no effect
        bus_write(2'd0, 8'hC3);
        bus_read(2'd0, d, dodd); chk("R2 R9 ctrl readback", d, 8'h43);
        bus_write(2'd0, 8'h8C);
        bus_read(2'd0, d, dodd); chk("R2 ctrl readback", d, 8'h0C);

        // R12 value byte access
        bus_write(2'd1, 8'h5A); bus_write(2'd2, 8'hA5);
        bus_read(2'd1, lo, dodd); bus_read(2'd2, hi, dodd);
        chk("R12 value bytes", rd16(lo, hi), 16'hA55A);

        // R11 odd channel reserved bit
        bus_write(2'd0, 8'h20);
        bus_read(2'd0, d, dodd);
        chk("R11 odd bit5", dodd, 8'h00);
        chk("R2 even bit5", d, 8'h20);

        // R3 random capture edges under random edge selects
        for (int i = 0; i < 16; i++) begin
            logic [1:0] es;
            logic nl, ol, hit;
            logic [15:0] cv;
            es = 2'($urandom % 4);
            bus_write(2'd0, {6'b0, es} << 2);
            bus_read(2'd0, d, dodd);
            bus_write(2'd0, {4'b0, es, 2'b00});
            bus_write(2'd1, 8'h00); bus_write(2'd2, 8'h00);
            bus_read(2'd0, d, dodd);
            chk("R6 pre-clear flag", d[7], 1'b0);
            ol = pin_in;
            nl = 1'($urandom % 2);
            cv = 16'($urandom);
            cnt_val = cv;
            set_pin(nl);
            hit = exp_cap(es, ol, nl);
            bus_read(2'd0, d, dodd);
            chk("R3 capture flag", d[7], hit);
            bus_read(2'd1, lo, dodd); bus_read(2'd2, hi, dodd);
            chk("R3 captured value", rd16(lo, hi), hit ? cv : 16'h0000);
        end

        // R3 directed rising edge with interrupts on; R10 irq
        bus_write(2'd0, 8'h44);
        bus_read(2'd0, d, dodd); bus_write(2'd0, 8'h44);
        set_pin(1'b0);
        cnt_val = 16'h1357;
        set_pin(1'b1);
        chk("R10 irq with enable", irq, 1'b1);
        bus_read(2'd1, lo, dodd); bus_read(2'd2, hi, dodd);
        chk("R3 rising capture", rd16(lo, hi), 16'h1357);

        // R7 write 0 without arming read keeps flag
        bus_write(2'd0, 8'h44);
        chk("R7 unarmed clear", irq, 1'b1);
        bus_write(2'd0, 8'h04);
        chk("R10 irq disabled", irq, 1'b0);
        bus_write(2'd0, 8'h44);

        // R8 event between read and write cancels the clear
        bus_read(2'd0, d, dodd); chk("R8 arm read flag", d[7], 1'b1);
        set_pin(1'b0); set_pin(1'b1);
        bus_write(2'd0, 8'h44);
        bus_read(2'd0, d, dodd); chk("R8 flag kept", d[7], 1'b1);

        // R6 proper handshake clears
        bus_write(2'd0, 8'h44);
        bus_read(2'd0, d, dodd); chk("R6 flag cleared", d[7], 1'b0);
        chk("R6 irq low", irq, 1'b0);

        // R4 R5 compare mode: value 0x0040, toggle, clear, set
        cnt_val = 16'h0000;
        bus_write(2'd1, 8'h40); bus_write(2'd2, 8'h00);
        for (int k = 0; k < 4; k++) begin
            logic [1:0] act;
            logic exp_pin;
            act = (k == 0) ? 2'b01 : (k == 1) ? 2'b01 : (k == 2) ? 2'b10 : 2'b11;
            exp_pin = (k == 0) ? 1'b1 : (k == 1) ? 1'b0 : (k == 2) ? 1'b0 : 1'b1;
            bus_write(2'd0, {4'b0001, act, 2'b00});
            bus_read(2'd0, d, dodd);
            bus_write(2'd0, {4'b0001, act, 2'b00});
            @(negedge clk); cnt_val = 16'h003F;
            @(negedge clk); cnt_val = 16'h0040;
            @(negedge clk); cnt_val = 16'h0041;
            chk("R5 compare pin", pin_out, exp_pin);
            bus_read(2'd0, d, dodd);
            chk("R4 compare flag", d[7], 1'b1);
            cnt_val = 16'h0000;
        end

        // R4 no match means no flag
        bus_read(2'd0, d, dodd); bus_write(2'd0, 8'h1C);
        @(negedge clk); cnt_val = 16'h0041;
        @(negedge clk); cnt_val = 16'h0000;
        bus_read(2'd0, d, dodd); chk("R4 no match", d[7], 1'b0);

        report();
    end
endmodule